// File: doc/BRIEF.md
# Masked Control Register Bank

This block holds a bank of 64-bit internal control registers that a processor core reaches by a 6-bit index through a simple request port. Each index has its own write and read behaviour. A write can be kept through a bit mask, forced to zero, forced to one, or refused with a fault. A read returns the stored value, returns the stored upper half joined with a live cycle counter, or is refused with a fault.

Writes to six of the registers are really control commands for the instruction-side and data-side translation buffers. The block turns each of those writes into a one-cycle strobe, and for single-entry invalidates it also gives the target address and the current address-space ID. A suppress input makes any write in the same cycle a no-op, which the core uses for requests issued on a wrong path.

Top module: `ipr_file`

## Requirements
- R1: After the synchronous active-high reset every register reads zero, except the memory-control register (index 9), which reads 0x6, and the firmware-base register (index 8), which reads the FW_BASE parameter.
- R2: A write stores the data ANDed with a per-index mask. The masks are: 0x1f for the priority level (10); 0xf for the trap request and trap enable (11, 12); 0x18 for the current, data and alternate mode (13, 14, 15); 0x7fff0 for the software request (16); 0xffffff0300 for the control/status (17); 0xffffffffc0000000 for both page-table bases (18, 19); 0x1ffb for the cache test control (20); 0x3f for the cache mode and miss-file mode (21, 22); 0x7f0 for the instruction ASID (23); 0xfe00000000000000 for the data ASID (24). The scratch registers 0-7, indices 8, 9 and the cycle register 33 keep all 64 bits.
- R3: A write to the restart-address register (25) stores the data with bit 1 cleared.
- R4: Any write to the exception summary (26) or exception mask (27) leaves that register at zero, whatever the data.
- R5: A write to index 28, 29, 30, 31 or 32 raises the fault flag and leaves the stored value unchanged. These indices stay readable.
- R6: A read of index 15 or of 35 through 44 raises the fault flag and returns zero. Indices 45 through 63 fault on both read and write.
- R7: A read of the cycle register (33) returns the stored bits 63:32 above the low 32 bits of a counter. The counter is zero in reset and counts up by one on every clock after reset.
- R8: Any write to the counter-control register (34) sets it to 1.
- R9: A write to 39 (data invalidate-all), 40 (data invalidate-process), 42 (instruction invalidate-all) or 43 (instruction invalidate-process) stores zero and pulses its own strobe for one cycle. No other strobe is high in that cycle.
- R10: A write to 41 (data invalidate-one) or 44 (instruction invalidate-one) stores the data and pulses its strobe. In the same cycle, inv_addr carries the written data and inv_asid carries the data ASID bits 63:57 or the instruction ASID bits 10:4 respectively.
- R11: While suppress is high, a write changes no register, fires no strobe and raises no fault.
- R12: Every accepted request gets rsp_valid, rsp_fault and rsp_rdata exactly one cycle later, with strobes in that same cycle. rsp_valid is low in the cycle after no request, and rsp_rdata is zero for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 6 | Register index |
| req_wdata | input | 64 | Write data |
| suppress | input | 1 | Turns writes in this cycle into no-ops |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | Unimplemented-access fault |
| rsp_rdata | output | 64 | Read data, zero on fault or write |
| dinv_all | output | 1 | Data buffer invalidate-all strobe |
| dinv_proc | output | 1 | Data buffer invalidate-process strobe |
| dinv_one | output | 1 | Data buffer invalidate-single strobe |
| iinv_all | output | 1 | Instruction buffer invalidate-all strobe |
| iinv_proc | output | 1 | Instruction buffer invalidate-process strobe |
| iinv_one | output | 1 | Instruction buffer invalidate-single strobe |
| inv_addr | output | 64 | Address for a single-entry invalidate |
| inv_asid | output | 7 | Address-space ID for a single-entry invalidate |

## Verification
The assertions take for granted that req_write, req_idx and suppress are known whenever req_valid is high, and that each request is one cycle long. Nothing on the port holds a request, so the bench drives one request in a cycle and then one idle cycle. Random indices cover all 64 codes, including the unknown ones. Suppress is drawn about one time in eight, and because writes are spread over every index, strobes and masked fields change under the bench's reference model.

// File: rtl/ipr_pkg.sv
package ipr_pkg;

    localparam int IDX_W    = 6;
    localparam int DATA_W   = 64;
    localparam int CNT_W    = 32;
    localparam int ASID_W   = 7;
    localparam int NUM_REGS = 45;
    localparam int N_SCR    = 8;

    localparam logic [IDX_W-1:0] X_FWBASE  = 6'd8;
    localparam logic [IDX_W-1:0] X_MEMCTL  = 6'd9;
    localparam logic [IDX_W-1:0] X_PRIO    = 6'd10;
    localparam logic [IDX_W-1:0] X_TRAPREQ = 6'd11;
    localparam logic [IDX_W-1:0] X_TRAPEN  = 6'd12;
    localparam logic [IDX_W-1:0] X_MODEC   = 6'd13;
    localparam logic [IDX_W-1:0] X_MODED   = 6'd14;
    localparam logic [IDX_W-1:0] X_MODEA   = 6'd15;
    localparam logic [IDX_W-1:0] X_SWREQ   = 6'd16;
    localparam logic [IDX_W-1:0] X_CSTAT   = 6'd17;
    localparam logic [IDX_W-1:0] X_IPTB    = 6'd18;
    localparam logic [IDX_W-1:0] X_DPTB    = 6'd19;
    localparam logic [IDX_W-1:0] X_CTEST   = 6'd20;
    localparam logic [IDX_W-1:0] X_CMODE   = 6'd21;
    localparam logic [IDX_W-1:0] X_MFMODE  = 6'd22;
    localparam logic [IDX_W-1:0] X_IASID   = 6'd23;
    localparam logic [IDX_W-1:0] X_DASID   = 6'd24;
    localparam logic [IDX_W-1:0] X_RESTART = 6'd25;
    localparam logic [IDX_W-1:0] X_EXCSUM  = 6'd26;
    localparam logic [IDX_W-1:0] X_EXCMSK  = 6'd27;
    localparam logic [IDX_W-1:0] X_RO_LO   = 6'd28;
    localparam logic [IDX_W-1:0] X_RO_HI   = 6'd32;
    localparam logic [IDX_W-1:0] X_CYC     = 6'd33;
    localparam logic [IDX_W-1:0] X_CYCCTL  = 6'd34;
    localparam logic [IDX_W-1:0] X_WO_LO   = 6'd35;
    localparam logic [IDX_W-1:0] X_WO_HI   = 6'd38;
    localparam logic [IDX_W-1:0] X_DALL    = 6'd39;
    localparam logic [IDX_W-1:0] X_DPROC   = 6'd40;
    localparam logic [IDX_W-1:0] X_DONE    = 6'd41;
    localparam logic [IDX_W-1:0] X_IALL    = 6'd42;
    localparam logic [IDX_W-1:0] X_IPROC   = 6'd43;
    localparam logic [IDX_W-1:0] X_IONE    = 6'd44;

    localparam int IASID_LSB = 4;
    localparam int DASID_LSB = 57;

    typedef enum logic [1:0] {W_MASK, W_ZERO, W_ONE, W_REJECT} wr_kind_e;
    typedef enum logic [1:0] {R_PLAIN, R_CYCLE, R_REJECT} rd_kind_e;
    typedef enum logic [2:0] {S_NONE, S_DALL, S_DPROC, S_DONE,
                              S_IALL, S_IPROC, S_IONE} strobe_e;

    typedef struct packed {
        wr_kind_e          wk;
        rd_kind_e          rk;
        strobe_e           sk;
        logic [DATA_W-1:0] mask;
    } reg_attr_t;

    localparam logic [DATA_W-1:0] ALL1 = '1;

    function automatic reg_attr_t mk(wr_kind_e w, rd_kind_e r, strobe_e s,
                                     logic [DATA_W-1:0] m);
        reg_attr_t a;
        a.wk = w; a.rk = r; a.sk = s; a.mask = m;
        return a;
    endfunction

    function automatic reg_attr_t attr_of(logic [IDX_W-1:0] idx);
        reg_attr_t a;
        a = mk(W_REJECT, R_REJECT, S_NONE, '0);
        if (int'(idx) < N_SCR) begin
            a = mk(W_MASK, R_PLAIN, S_NONE, ALL1);
        end else if (idx >= X_RO_LO && idx <= X_RO_HI) begin
            a = mk(W_REJECT, R_PLAIN, S_NONE, '0);
        end else if (idx >= X_WO_LO && idx <= X_WO_HI) begin
            a = mk(W_MASK, R_REJECT, S_NONE, ALL1);
        end else begin
            case (idx)
                X_FWBASE, X_MEMCTL: a = mk(W_MASK, R_PLAIN, S_NONE, ALL1);
                X_PRIO:             a = mk(W_MASK, R_PLAIN, S_NONE, 64'h1f);
                X_TRAPREQ, X_TRAPEN:a = mk(W_MASK, R_PLAIN, S_NONE, 64'hf);
                X_MODEC, X_MODED:   a = mk(W_MASK, R_PLAIN, S_NONE, 64'h18);
                X_MODEA:            a = mk(W_MASK, R_REJECT, S_NONE, 64'h18);
                X_SWREQ:            a = mk(W_MASK, R_PLAIN, S_NONE, 64'h7fff0);
                X_CSTAT:            a = mk(W_MASK, R_PLAIN, S_NONE, 64'hff_ffff_0300);
                X_IPTB, X_DPTB:     a = mk(W_MASK, R_PLAIN, S_NONE, 64'hffff_ffff_c000_0000);
                X_CTEST:            a = mk(W_MASK, R_PLAIN, S_NONE, 64'h1ffb);
                X_CMODE, X_MFMODE:  a = mk(W_MASK, R_PLAIN, S_NONE, 64'h3f);
                X_IASID:            a = mk(W_MASK, R_PLAIN, S_NONE, 64'h7f0);
                X_DASID:            a = mk(W_MASK, R_PLAIN, S_NONE, 64'hfe00_0000_0000_0000);
                X_RESTART:          a = mk(W_MASK, R_PLAIN, S_NONE, ~64'h2);
                X_EXCSUM, X_EXCMSK: a = mk(W_ZERO, R_PLAIN, S_NONE, '0);
                X_CYC:              a = mk(W_MASK, R_CYCLE, S_NONE, ALL1);
                X_CYCCTL:           a = mk(W_ONE, R_PLAIN, S_NONE, '0);
                X_DALL:             a = mk(W_ZERO, R_REJECT, S_DALL, '0);
                X_DPROC:            a = mk(W_ZERO, R_REJECT, S_DPROC, '0);
                X_DONE:             a = mk(W_MASK, R_REJECT, S_DONE, ALL1);
                X_IALL:             a = mk(W_ZERO, R_REJECT, S_IALL, '0);
                X_IPROC:            a = mk(W_ZERO, R_REJECT, S_IPROC, '0);
                X_IONE:             a = mk(W_MASK, R_REJECT, S_IONE, ALL1);
                default:            a = mk(W_REJECT, R_REJECT, S_NONE, '0);
            endcase
        end
        return a;
    endfunction

    function automatic logic [DATA_W-1:0] reset_of(int i, logic [DATA_W-1:0] fw);
        if (i == int'(X_FWBASE)) return fw;
        if (i == int'(X_MEMCTL)) return 64'h6;
        return '0;
    endfunction

endpackage

// File: rtl/ipr_decode.sv
module ipr_decode
    import ipr_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output reg_attr_t        attr
);
    always_comb attr = attr_of(idx);
endmodule

// File: rtl/ipr_cycle_ctr.sv
module ipr_cycle_ctr
    import ipr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + 1'b1;
    end
endmodule

// File: rtl/ipr_store.sv
module ipr_store
    import ipr_pkg::*;
#(
    parameter logic [DATA_W-1:0] FW_BASE = 64'h0000_0000_0001_0000
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              we,
    input  logic [IDX_W-1:0]                  widx,
    input  logic [DATA_W-1:0]                 wval,
    output logic [NUM_REGS-1:0][DATA_W-1:0]   regs
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [DATA_W-1:0] RST_VAL = reset_of(i, FW_BASE);
        logic [DATA_W-1:0] r;
        always_ff @(posedge clk) begin
            if (rst)                             r <= RST_VAL;
            else if (we && widx == IDX_W'(i))    r <= wval;
        end
        assign regs[i] = r;
    end
endmodule

// File: rtl/ipr_strobe.sv
module ipr_strobe
    import ipr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  strobe_e           sk,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ASID_W-1:0] iasid,
    input  logic [ASID_W-1:0] dasid,
    output logic              dinv_all,
    output logic              dinv_proc,
    output logic              dinv_one,
    output logic              iinv_all,
    output logic              iinv_proc,
    output logic              iinv_one,
    output logic [DATA_W-1:0] inv_addr,
    output logic [ASID_W-1:0] inv_asid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dinv_all <= 1'b0; dinv_proc <= 1'b0; dinv_one <= 1'b0;
            iinv_all <= 1'b0; iinv_proc <= 1'b0; iinv_one <= 1'b0;
            inv_addr <= '0;   inv_asid  <= '0;
        end else begin
            dinv_all  <= fire && sk == S_DALL;
            dinv_proc <= fire && sk == S_DPROC;
            dinv_one  <= fire && sk == S_DONE;
            iinv_all  <= fire && sk == S_IALL;
            iinv_proc <= fire && sk == S_IPROC;
            iinv_one  <= fire && sk == S_IONE;
            if (fire && sk == S_DONE) begin
                inv_addr <= wdata;
                inv_asid <= dasid;
            end else if (fire && sk == S_IONE) begin
                inv_addr <= wdata;
                inv_asid <= iasid;
            end
        end
    end
endmodule

// File: rtl/ipr_file.sv
module ipr_file
    import ipr_pkg::*;
#(
    parameter logic [DATA_W-1:0] FW_BASE = 64'h0000_0000_0001_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [5:0]        req_idx,
    input  logic [63:0]       req_wdata,
    input  logic              suppress,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [63:0]       rsp_rdata,
    output logic              dinv_all,
    output logic              dinv_proc,
    output logic              dinv_one,
    output logic              iinv_all,
    output logic              iinv_proc,
    output logic              iinv_one,
    output logic [63:0]       inv_addr,
    output logic [6:0]        inv_asid
);
    reg_attr_t                       attr;
    logic [CNT_W-1:0]                cyc;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic                            wr_go;
    logic [DATA_W-1:0]               wval;
    logic [IDX_W-1:0]                sidx;
    logic [DATA_W-1:0]               sel;
    logic [DATA_W-1:0]               rd_val;
    logic                            rd_flt;

    ipr_decode u_dec (.idx(req_idx), .attr(attr));

    ipr_cycle_ctr u_ctr (.clk(clk), .rst(rst), .count(cyc));

    always_comb begin
        wr_go = req_valid && req_write && !suppress && attr.wk != W_REJECT;
        case (attr.wk)
            W_MASK:  wval = req_wdata & attr.mask;
            W_ONE:   wval = DATA_W'(1);
            default: wval = '0;
        endcase
    end

    ipr_store #(.FW_BASE(FW_BASE)) u_store (
        .clk(clk), .rst(rst), .we(wr_go), .widx(req_idx),
        .wval(wval), .regs(regs)
    );

    always_comb begin
        sidx = (int'(req_idx) < NUM_REGS) ? req_idx : '0;
        sel  = regs[sidx];
        case (attr.rk)
            R_PLAIN:  rd_val = sel;
            R_CYCLE:  rd_val = {sel[DATA_W-1:CNT_W], cyc};
            default:  rd_val = '0;
        endcase
        rd_flt = req_write ? (attr.wk == W_REJECT && !suppress)
                           : (attr.rk == R_REJECT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_fault <= req_valid && rd_flt;
            rsp_rdata <= (req_valid && !req_write) ? rd_val : '0;
        end
    end

    ipr_strobe u_stb (
        .clk(clk), .rst(rst), .fire(wr_go), .sk(attr.sk), .wdata(req_wdata),
        .iasid(regs[X_IASID][IASID_LSB +: ASID_W]),
        .dasid(regs[X_DASID][DASID_LSB +: ASID_W]),
        .dinv_all(dinv_all), .dinv_proc(dinv_proc), .dinv_one(dinv_one),
        .iinv_all(iinv_all), .iinv_proc(iinv_proc), .iinv_one(iinv_one),
        .inv_addr(inv_addr), .inv_asid(inv_asid)
    );
endmodule

// File: rtl/ipr_file_chk.sv
module ipr_file_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic [5:0]  req_idx,
    input logic        suppress,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [63:0] rsp_rdata,
    input logic [5:0]  strobes
);
    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R12
    AST_NO_IDLE_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R12
    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobes)); // R9
    AST_SUPPRESS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && suppress) |=> (strobes == 6'b0 && !rsp_fault)); // R11
    AST_RO_FAULT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !suppress && req_idx >= 6'd28 && req_idx <= 6'd32)
        |=> rsp_fault); // R5
    AST_WO_READ_FAULT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_idx >= 6'd35 && req_idx <= 6'd44)
        |=> (rsp_fault && rsp_rdata == 64'b0)); // R6
    AST_PRIO_MASK: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_idx == 6'd10) |=> rsp_rdata[63:5] == 59'b0); // R2
    AST_RESTART_BIT1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_idx == 6'd25) |=> !rsp_rdata[1]); // R3
endmodule

bind ipr_file ipr_file_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_idx(req_idx), .suppress(suppress), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata),
    .strobes({dinv_all, dinv_proc, dinv_one, iinv_all, iinv_proc, iinv_one})
);

// File: tb/ipr_file_bench.sv
module ipr_file_bench;
    localparam logic [63:0] FWB = 64'h0000_0000_0001_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, suppress = 1'b0;
    logic [5:0]  req_idx = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, rsp_fault;
    logic [63:0] rsp_rdata, inv_addr;
    logic        dinv_all, dinv_proc, dinv_one, iinv_all, iinv_proc, iinv_one;
    logic [6:0]  inv_asid;

    int unsigned errors = 0, checks = 0;
    logic [31:0] cyc = '0;
    logic [63:0] model [64];
    bit          done = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= '0;
        else     cyc <= cyc + 1;
    end

    ipr_file u_ipr_file (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_idx(req_idx), .req_wdata(req_wdata), .suppress(suppress),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata),
        .dinv_all(dinv_all), .dinv_proc(dinv_proc), .dinv_one(dinv_one),
        .iinv_all(iinv_all), .iinv_proc(iinv_proc), .iinv_one(iinv_one),
        .inv_addr(inv_addr), .inv_asid(inv_asid)
    );

    // write kind: 0 masked store, 1 zero, 2 one, 3 reject
    function automatic int m_wk(int i);
        if (i >= 28 && i <= 32) return 3;
        if (i >= 45) return 3;
        if (i == 26 || i == 27 || i == 39 || i == 40 || i == 42 || i == 43) return 1;
        if (i == 34) return 2;
        return 0;
    endfunction

    // read kind: 0 plain, 1 cycle splice, 2 reject
    function automatic int m_rk(int i);
        if (i == 15 || (i >= 35 && i <= 63)) return 2;
        if (i == 33) return 1;
        return 0;
    endfunction

    function automatic logic [63:0] m_mask(int i);
        case (i)
            10: return 64'h1f;
            11, 12: return 64'hf;
            13, 14, 15: return 64'h18;
            16: return 64'h7fff0;
            17: return 64'hff_ffff_0300;
            18, 19: return 64'hffff_ffff_c000_0000;
            20: return 64'h1ffb;
            21, 22: return 64'h3f;
            23: return 64'h7f0;
            24: return 64'hfe00_0000_0000_0000;
            25: return ~64'h2;
            default: return '1;
        endcase
    endfunction

    // strobe vector {dall,dproc,done,iall,iproc,ione}
    function automatic logic [5:0] m_stb(int i);
        case (i)
            39: return 6'b100000;
            40: return 6'b010000;
            41: return 6'b001000;
            42: return 6'b000100;
            43: return 6'b000010;
            44: return 6'b000001;
            default: return 6'b0;
        endcase
    endfunction

    function automatic string tag_of(int i, bit wr, bit sup);
        if (wr && sup) return "R11";
        if (wr && (i == 39 || i == 40 || i == 42 || i == 43)) return "R9";
        if (wr && (i == 41 || i == 44)) return "R10";
        if (wr && i == 34) return "R8";
        if (wr && (i == 26 || i == 27)) return "R4";
        if (wr && i == 25) return "R3";
        if (wr && m_wk(i) == 3) return "R5";
        if (wr) return "R2";
        if (m_rk(i) == 2) return "R6";
        if (m_rk(i) == 1) return "R7";
        return "R2";
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xact(int i, bit wr, logic [63:0] d, bit sup, string tag_in = "");
        logic [63:0] e_rd;
        bit          e_flt;
        logic [5:0]  e_stb, a_stb;
        logic [6:0]  e_asid;
        string       t;
        t = (tag_in != "") ? tag_in : tag_of(i, wr, sup);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_idx = 6'(i);
        req_wdata = d; suppress = sup;
        e_rd = '0; e_flt = 0; e_stb = '0;
        e_asid = (i == 41) ? model[24][63:57] : model[23][10:4];
        if (wr) begin
            if (!sup) begin
                e_flt = (m_wk(i) == 3);
                e_stb = m_stb(i);
                case (m_wk(i))
                    0: model[i] = d & m_mask(i);
                    1: model[i] = '0;
                    2: model[i] = 64'd1;
                    default: ;
                endcase
            end
        end else begin
            case (m_rk(i))
                0: e_rd = model[i];
                1: e_rd = {model[i][63:32], cyc};
                default: e_flt = 1;
            endcase
        end
        @(negedge clk);
        req_valid = 1'b0;
        a_stb = {dinv_all, dinv_proc, dinv_one, iinv_all, iinv_proc, iinv_one};
        check(rsp_valid === 1'b1, "R12", 64'(rsp_valid), 64'd1);
        check(rsp_fault === e_flt, t, 64'(rsp_fault), 64'(e_flt));
        check(rsp_rdata === e_rd, t, rsp_rdata, e_rd);
        check(a_stb === e_stb, t, 64'(a_stb), 64'(e_stb));
        if (e_stb[3] || e_stb[0]) begin
            check(inv_addr === d, "R10", inv_addr, d);
            check(inv_asid === e_asid, "R10", 64'(inv_asid), 64'(e_asid));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] c0;
        void'($urandom(32'd7321));
        for (int i = 0; i < 64; i++) model[i] = '0;
        model[8] = FWB;
        model[9] = 64'h6;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset values across every readable index
        for (int i = 0; i < 64; i++) if (m_rk(i) != 2) xact(i, 0, '0, 0, "R1");
        // R12: no response after an idle cycle
        @(negedge clk);
        check(rsp_valid === 1'b0, "R12", 64'(rsp_valid), 64'd0);
        // R2: all-ones then readback through every masked register
        for (int i = 10; i <= 24; i++) begin
            xact(i, 1, '1, 0);
            if (m_rk(i) != 2) xact(i, 0, '0, 0, "R2");
        end
        // R3 restart bit 1
        xact(25, 1, '1, 0);
        xact(25, 0, '0, 0, "R3");
        // R4 clear on write
        xact(26, 1, 64'hdead_beef, 0);
        xact(26, 0, '0, 0, "R4");
        xact(27, 1, '1, 0);
        xact(27, 0, '0, 0, "R4");
        // R5 read-only rejects and keeps value
        for (int i = 28; i <= 32; i++) begin
            xact(i, 1, '1, 0);
            xact(i, 0, '0, 0, "R5");
        end
        // R6 write-only and unknown
        xact(15, 0, '0, 0, "R6");
        xact(50, 1, 64'h5, 0, "R6");
        xact(63, 0, '0, 0, "R6");
        // R7 cycle splice: counter advances between reads
        xact(33, 1, 64'h1234_5678_9abc_def0, 0);
        xact(33, 0, '0, 0, "R7");
        c0 = rsp_rdata[31:0];
        xact(33, 0, '0, 0, "R7");
        check(rsp_rdata[31:0] - c0 == 32'd2, "R7", 64'(rsp_rdata[31:0] - c0), 64'd2);
        // R8
        xact(34, 1, 64'hff00, 0);
        xact(34, 0, '0, 0, "R8");
        // R9 / R10 strobes with ASIDs set
        xact(24, 1, 64'hab00_0000_0000_0000, 0);
        xact(23, 1, 64'h0000_0000_0000_05a0, 0);
        for (int i = 39; i <= 44; i++) xact(i, 1, 64'h0000_0fed_cba9_8760 + 64'(i), 0);
        // R11 suppressed writes
        xact(3, 1, 64'h1111, 0);
        xact(3, 1, 64'h2222, 1);
        xact(3, 0, '0, 0, "R11");
        xact(41, 1, 64'h77, 1);
        xact(30, 1, 64'h77, 1);
        // mixed random traffic
        for (int n = 0; n < 1500; n++) begin
            int  i;
            bit  wr, sup;
            logic [63:0] d;
            i   = int'($urandom_range(63, 0));
            wr  = ($urandom_range(1, 0) == 1);
            sup = ($urandom_range(7, 0) == 0);
            d   = {$urandom, $urandom};
            xact(i, wr, d, sup);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule